// File: doc/BRIEF.md
# Sixteen-Bit Up-Counting Timer with Input Capture

This block is a timer peripheral built around a 16-bit counter that only counts upward. A small clock divider produces a count tick from the system clock at a rate chosen by a 3-bit select field. The counter either runs freely to 0xFFFF and rolls over, or clears on reaching a wrap value. That wrap value comes from the active copy of compare register A, or from the capture register. Software reaches every setting through a flat register port with one write strobe, one address and combinational read data.

Two compare channels, A and B, watch the count. When the count matches a channel, that channel sets its flag. If its toggle bit is set, it also inverts its output pin. A capture input is synchronized and edge-detected, and the selected edge copies the counter into the capture register. Four flags, each with its own enable bit, combine into one interrupt request. The flags are for capture, compare A, compare B and overflow.

Compare register A is written into a shadow copy. The count logic uses this shadow copy only after a wrap, or while the counter is stopped. The capture register acts at once when written. While the capture register serves as the wrap value, capture events from the pin are ignored.

Top module: `timer16_capture`

## Requirements
- R1: After reset every register reads 0, both compare pins are 0 and the interrupt request is 0.
- R2: Register map.
  - Address 0 is CTRL: bits [2:0] select the clock, bit 3 selects the capture edge (1 = rising, 0 = falling), bits [5:4] select the mode, bit 6 enables toggling of pin A and bit 7 enables toggling of pin B. Its upper bits read 0.
  - Address 1 is the counter, address 2 is compare A (reads the written value), address 3 is compare B and address 4 is capture.
  - Address 5 holds the interrupt enables in bits [3:0] and address 6 holds the flags in bits [3:0]. For both, bit 0 is capture, bit 1 is compare A, bit 2 is compare B and bit 3 is overflow.
  - Address 7 reads 0.
- R3: Clock select.
  - A value of 0, 6 or 7 stops the counter.
  - Values 1 to 5 give one count per 1, 8, 64, 256 or 1024 clocks.
  - A write to CTRL restarts the divider, so the first count lands exactly one full period after that write.
- R4: In mode 0 (free running), the counter rolls from 0xFFFF to 0 and sets the overflow flag. Mode 3 behaves as mode 0.
- R5: In mode 1, the wrap value is the active compare A value. A tick taken while the count equals the wrap value returns the count to 0.
- R6: A write to compare A reaches the active copy only at a wrap, or while the counter is stopped.
- R7: In mode 2, the capture register is the wrap value and a write to it takes effect at once. Edges on the capture pin neither change it nor set the capture flag.
- R8: Compare matches.
  - A tick taken while the count equals a channel's compare value sets that channel's flag. A count equal to the compare value with no tick sets nothing.
  - When the channel's toggle bit is 1, the same event inverts its pin. When the bit is 0, the pin holds.
- R9: Capture.
  - The pin passes through two synchronizer flops and an edge register.
  - A selected edge driven just after a clock edge stores the count present two clocks later, and sets the capture flag. The other edge does nothing.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle wins over a clear. The interrupt request is high exactly when a flag and its enable bit are both 1.
- R11: A write to the counter overrides the tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| cap_pin | input | 1 | Asynchronous capture input |
| oc_a | output | 1 | Compare A output pin |
| oc_b | output | 1 | Compare B output pin |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is telling the buffered compare A path apart from the immediate capture path in the middle of a count period. From the ports, both only show up as the point where the count wraps.

The stimulus writes a new wrap value while the counter is already running past the new value. It then counts the exact number of cycles to the next return to zero. With buffering, the old period must finish first. With the capture register, the longer value must take effect in that same period.

Capture latency is pinned in a similar way. The counter is preloaded with a register write, and the pin is driven on the following falling clock edge. This makes the captured value an exact number.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int REG_AW  = 3;
    localparam int NUM_CMP = 2;
    localparam int NFLAG   = 4;

    localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] A_COUNT = 3'd1;
    localparam logic [REG_AW-1:0] A_CMPA  = 3'd2;
    localparam logic [REG_AW-1:0] A_CMPB  = 3'd3;
    localparam logic [REG_AW-1:0] A_CAPT  = 3'd4;
    localparam logic [REG_AW-1:0] A_IEN   = 3'd5;
    localparam logic [REG_AW-1:0] A_FLAG  = 3'd6;

    localparam int F_CAP  = 0;
    localparam int F_CMPA = 1;
    localparam int F_CMPB = 2;
    localparam int F_OVF  = 3;

    typedef enum logic [1:0] {
        MODE_FREE    = 2'd0,
        MODE_CTC_CMP = 2'd1,
        MODE_CTC_CAP = 2'd2,
        MODE_RSVD    = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      tog_b;
        logic      tog_a;
        tmr_mode_e mode;
        logic      cap_rise;
        logic [2:0] clk_sel;
    } ctrl_t;

    function automatic logic sel_running(logic [2:0] sel);
        return (sel >= 3'd1) && (sel <= 3'd5);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PW = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam int LOG_S2 = 3;
    localparam int LOG_S3 = 6;
    localparam int LOG_S4 = 8;

    logic [PW-1:0] pc_d, pc_q;
    logic [PW-1:0] mask;

    always_comb begin
        unique case (sel)
            3'd2:    mask = PW'((1 << LOG_S2) - 1);
            3'd3:    mask = PW'((1 << LOG_S3) - 1);
            3'd4:    mask = PW'((1 << LOG_S4) - 1);
            3'd5:    mask = '1;
            default: mask = '0;
        endcase
        tick = tmr_pkg::sel_running(sel) && ((pc_q & mask) == mask);
        pc_d = clear ? '0 : pc_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/tmr_edge_detect.sv
module tmr_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin};
        rise = sh_q[STAGES-1] & ~sh_q[STAGES];
        fall = ~sh_q[STAGES-1] & sh_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp_val,
    input  logic         tog_en,
    output logic         match,
    output logic         pin
);
    logic pin_d, pin_q;

    always_comb begin
        match = tick && (count == cmp_val);
        pin_d = pin_q ^ (match & tog_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign pin = pin_q;
endmodule

// File: rtl/timer16_capture.sv
module timer16_capture
    import tmr_pkg::*;
#(
    parameter int W          = 16,
    parameter int PRESC_W    = 10,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic              cap_pin,
    output logic              oc_a,
    output logic              oc_b,
    output logic              irq
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam int CW = $bits(ctrl_t);

    typedef struct packed {
        logic [W-1:0]     cnt;
        ctrl_t            ctrl;
        logic [W-1:0]     cmpa_buf;
        logic [W-1:0]     cmpa_act;
        logic [W-1:0]     cmpb;
        logic [W-1:0]     capt;
        logic [NFLAG-1:0] ien;
        logic [NFLAG-1:0] flags;
    } state_t;

    state_t st_d, st_q;

    logic              tick;
    logic              cap_rise_ev, cap_fall_ev;
    logic [W-1:0]      cmp_vals [NUM_CMP];
    logic [NUM_CMP-1:0] tog_en, match, oc;

    // signals observed by the bound checker
    logic [W-1:0]     cnt_now, top_val, capt_now;
    logic [NFLAG-1:0] flags_now, ien_now;
    tmr_mode_e        mode_now;
    logic             run_now;

    tmr_prescaler #(.PW(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (wr_en && (addr == A_CTRL)),
        .sel   (st_q.ctrl.clk_sel),
        .tick  (tick)
    );

    tmr_edge_detect #(.STAGES(SYNC_DEPTH)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cap_pin),
        .rise  (cap_rise_ev),
        .fall  (cap_fall_ev)
    );

    assign cmp_vals[0] = st_q.cmpa_act;
    assign cmp_vals[1] = st_q.cmpb;
    assign tog_en      = {st_q.ctrl.tog_b, st_q.ctrl.tog_a};

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        tmr_cmp_chan #(.W(W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .count   (st_q.cnt),
            .cmp_val (cmp_vals[c]),
            .tog_en  (tog_en[c]),
            .match   (match[c]),
            .pin     (oc[c])
        );
    end

    logic             at_top, wrap, ovf_ev, cap_ev, running;
    logic [NFLAG-1:0] set_vec, clr_vec;

    always_comb begin
        running = sel_running(st_q.ctrl.clk_sel);

        unique case (st_q.ctrl.mode)
            MODE_CTC_CMP: top_val = st_q.cmpa_act;
            MODE_CTC_CAP: top_val = st_q.capt;
            default:      top_val = CNT_MAX;
        endcase

        at_top = (st_q.cnt == top_val);
        wrap   = tick && at_top;
        ovf_ev = tick && (st_q.cnt == CNT_MAX);
        cap_ev = (st_q.ctrl.cap_rise ? cap_rise_ev : cap_fall_ev)
                 && (st_q.ctrl.mode != MODE_CTC_CAP);

        set_vec         = '0;
        set_vec[F_CAP]  = cap_ev;
        set_vec[F_CMPA] = match[0];
        set_vec[F_CMPB] = match[1];
        set_vec[F_OVF]  = ovf_ev;
        clr_vec = (wr_en && addr == A_FLAG) ? wdata[NFLAG-1:0] : '0;

        st_d = st_q;

        // counter: software write overrides the tick
        if (wr_en && addr == A_COUNT) st_d.cnt = wdata;
        else if (tick)                st_d.cnt = at_top ? '0 : st_q.cnt + W'(1);

        if (wr_en && addr == A_CTRL) st_d.ctrl = ctrl_t'(wdata[CW-1:0]);
        if (wr_en && addr == A_CMPA) st_d.cmpa_buf = wdata;
        if (wr_en && addr == A_CMPB) st_d.cmpb = wdata;
        if (wr_en && addr == A_IEN)  st_d.ien = wdata[NFLAG-1:0];

        // shadow copy of compare A moves only at wrap or while stopped
        if (wrap || !running) st_d.cmpa_act = st_q.cmpa_buf;

        if (wr_en && addr == A_CAPT) st_d.capt = wdata;
        else if (cap_ev)             st_d.capt = st_q.cnt;

        st_d.flags = (st_q.flags & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = W'(st_q.ctrl);
            A_COUNT: rdata = st_q.cnt;
            A_CMPA:  rdata = st_q.cmpa_buf;
            A_CMPB:  rdata = st_q.cmpb;
            A_CAPT:  rdata = st_q.capt;
            A_IEN:   rdata = W'(st_q.ien);
            A_FLAG:  rdata = W'(st_q.flags);
            default: rdata = '0;
        endcase
    end

    assign oc_a = oc[0];
    assign oc_b = oc[1];
    assign irq  = |(st_q.flags & st_q.ien);

    assign cnt_now   = st_q.cnt;
    assign capt_now  = st_q.capt;
    assign flags_now = st_q.flags;
    assign ien_now   = st_q.ien;
    assign mode_now  = st_q.ctrl.mode;
    assign run_now   = running;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] addr,
    input logic              tick,
    input logic              run_now,
    input logic [W-1:0]      cnt_now,
    input logic [W-1:0]      top_val,
    input logic [W-1:0]      capt_now,
    input tmr_mode_e         mode_now,
    input logic [NUM_CMP-1:0] tog_en,
    input logic              oc_a,
    input logic              oc_b,
    input logic [NFLAG-1:0]  flags_now,
    input logic [NFLAG-1:0]  ien_now,
    input logic              irq
);
    logic cnt_wr, capt_wr;
    assign cnt_wr  = wr_en && (addr == A_COUNT);
    assign capt_wr = wr_en && (addr == A_CAPT);

    assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_now && !cnt_wr) |=> $stable(cnt_now));

    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt_now != top_val) && !cnt_wr) |=> (cnt_now == $past(cnt_now) + W'(1)));

    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt_now == top_val) && !cnt_wr) |=> (cnt_now == '0));

    assert_capt_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_now == MODE_CTC_CAP) && !capt_wr) |=> $stable(capt_now));

    assert_pin_a_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tog_en[0] |=> $stable(oc_a));

    assert_pin_b_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tog_en[1] |=> $stable(oc_b));

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_now & ien_now) == '0) |-> !irq);
endmodule

bind timer16_capture tmr_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .tick      (tick),
    .run_now   (run_now),
    .cnt_now   (cnt_now),
    .top_val   (top_val),
    .capt_now  (capt_now),
    .mode_now  (mode_now),
    .tog_en    (tog_en),
    .oc_a      (oc_a),
    .oc_b      (oc_b),
    .flags_now (flags_now),
    .ien_now   (ien_now),
    .irq       (irq)
);

// File: tb/tb_timer16_capture.sv
module tb_timer16_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        cap_pin = 1'b0;
    logic        oc_a, oc_b, irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    timer16_capture dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_pin(cap_pin), .oc_a(oc_a), .oc_b(oc_b), .irq(irq)
    );

    // {address, write data, expected readback}
    localparam logic [34:0] VEC [9] = '{
        {3'd0, 16'hFF98, 16'h0098},
        {3'd1, 16'hBEEF, 16'hBEEF},
        {3'd2, 16'h1111, 16'h1111},
        {3'd3, 16'h2222, 16'h2222},
        {3'd4, 16'h3333, 16'h3333},
        {3'd5, 16'hFFF5, 16'h0005},
        {3'd6, 16'h000F, 16'h0000},
        {3'd0, 16'h0000, 16'h0000},
        {3'd7, 16'h5555, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic pa, pb;
        wait_n(3);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reg", v, 0);
        end
        chk("R1 pins", {oc_a, oc_b, irq}, 0);

        // R2 register table
        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][34:32], VEC[i][31:16]);
            rd(VEC[i][34:32], v);
            chk("R2 readback", v, VEC[i][15:0]);
        end

        // R5 R8 CTC on compare A with toggles
        wr(3'd5, 16'h0);
        wr(3'd3, 16'd3);
        wr(3'd2, 16'd5);
        wr(3'd1, 16'd0);
        wr(3'd6, 16'hF);
        wr(3'd0, 16'h00D1);
        wait_n(4);
        rd(3'd1, v); chk("R5 count", v, 4);
        chk("R8 pin b toggled", oc_b, 1);
        chk("R8 pin a held", oc_a, 0);
        wait_n(2);
        rd(3'd1, v); chk("R5 wrap", v, 0);
        chk("R8 pin a toggled", oc_a, 1);
        rd(3'd6, v); chk("R8 flags A B", v, 16'h6);

        // R6 buffered compare A
        wr(3'd2, 16'd2);
        wait_n(4);
        rd(3'd1, v); chk("R6 old top kept", v, 5);
        wait_n(1);
        rd(3'd1, v); chk("R6 wrap", v, 0);
        wait_n(2);
        rd(3'd1, v); chk("R6 new top", v, 2);
        wait_n(1);
        rd(3'd1, v); chk("R6 new wrap", v, 0);
        chk("R8 pin a again", oc_a, 1);

        // R3 stop
        wr(3'd0, 16'h0000);
        wait_n(20);
        rd(3'd1, v); chk("R3 stopped", v, 1);

        // R8 toggle disabled
        wr(3'd6, 16'hF);
        pa = oc_a; pb = oc_b;
        wr(3'd0, 16'h0011);
        wait_n(12);
        chk("R8 pins held", {oc_a, oc_b}, {pa, pb});
        rd(3'd6, v); chk("R8 flag A only", v, 16'h2);
        wr(3'd0, 16'h0000);

        // R4 overflow, R10 flags and irq
        wr(3'd1, 16'hFFFE);
        wr(3'd6, 16'hF);
        wr(3'd0, 16'h0001);
        wait_n(1);
        rd(3'd1, v); chk("R4 max", v, 16'hFFFF);
        wait_n(1);
        rd(3'd1, v); chk("R4 rollover", v, 0);
        rd(3'd6, v); chk("R4 overflow flag", v, 16'h8);
        chk("R10 irq masked", irq, 0);
        wr(3'd0, 16'h0000);
        wr(3'd5, 16'h0008);
        chk("R10 irq on", irq, 1);
        wr(3'd6, 16'h0001);
        rd(3'd6, v); chk("R10 other bit kept", v, 16'h8);
        chk("R10 irq stays", irq, 1);
        wr(3'd6, 16'h0008);
        rd(3'd6, v); chk("R10 cleared", v, 0);
        chk("R10 irq off", irq, 0);
        wr(3'd5, 16'h0);

        // R9 R11 capture while running
        wr(3'd0, 16'h0009);
        wr(3'd1, 16'd100);
        rd(3'd1, v); chk("R11 write wins", v, 100);
        cap_pin = 1'b1;
        wait_n(3);
        rd(3'd4, v); chk("R9 capture value", v, 102);
        rd(3'd6, v); chk("R9 capture flag", v[0], 1);
        wr(3'd0, 16'h0008);

        // R9 edge select
        wr(3'd1, 16'h1234);
        wr(3'd6, 16'hF);
        cap_pin = 1'b0;
        wait_n(4);
        rd(3'd4, v); chk("R9 fall ignored", v, 102);
        rd(3'd6, v); chk("R9 no flag fall", v[0], 0);
        wr(3'd0, 16'h0000);
        cap_pin = 1'b1;
        wait_n(4);
        rd(3'd4, v); chk("R9 rise ignored", v, 102);
        rd(3'd6, v); chk("R9 no flag rise", v[0], 0);
        cap_pin = 1'b0;
        wait_n(4);
        rd(3'd4, v); chk("R9 fall captured", v, 16'h1234);
        rd(3'd6, v); chk("R9 flag set", v[0], 1);

        // R7 CTC on capture register
        wr(3'd6, 16'hF);
        wr(3'd4, 16'd3);
        wr(3'd1, 16'd0);
        wr(3'd0, 16'h0021);
        wait_n(4);
        rd(3'd1, v); chk("R7 wrap at 3", v, 0);
        wr(3'd4, 16'd10);
        wait_n(3);
        rd(3'd1, v); chk("R7 immediate top", v, 4);
        wait_n(6);
        rd(3'd1, v); chk("R7 reach 10", v, 10);
        wait_n(1);
        rd(3'd1, v); chk("R7 wrap at 10", v, 0);
        cap_pin = 1'b1; wait_n(4);
        cap_pin = 1'b0; wait_n(4);
        rd(3'd4, v); chk("R7 capture ignored", v, 10);
        rd(3'd6, v); chk("R7 no capture flag", v[0], 0);
        wr(3'd0, 16'h0000);

        // R3 prescaler rates
        wr(3'd1, 16'd0);
        wr(3'd0, 16'h0002);
        wait_n(7);
        rd(3'd1, v); chk("R3 div8 early", v, 0);
        wait_n(1);
        rd(3'd1, v); chk("R3 div8", v, 1);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'd0);
        wr(3'd0, 16'h0003);
        wait_n(63);
        rd(3'd1, v); chk("R3 div64 early", v, 0);
        wait_n(1);
        rd(3'd1, v); chk("R3 div64", v, 1);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'd0);
        wr(3'd0, 16'h0004);
        wait_n(255);
        rd(3'd1, v); chk("R3 div256 early", v, 0);
        wait_n(1);
        rd(3'd1, v); chk("R3 div256", v, 1);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'd0);
        wr(3'd0, 16'h0005);
        wait_n(1023);
        rd(3'd1, v); chk("R3 div1024 early", v, 0);
        wait_n(1);
        rd(3'd1, v); chk("R3 div1024", v, 1);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'd5);
        wr(3'd0, 16'h0006);
        wait_n(30);
        rd(3'd1, v); chk("R3 select 6 stops", v, 5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule